// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block keeps a small bank of cached segment registers (one for code, one for data by default). Each register is filled by a single-cycle load that presents a 16-bit selector together with the 64-bit descriptor already fetched for it. The block unpacks the descriptor into a 32-bit base, a 20-bit limit that is scaled by a granularity flag, a present flag, a size flag, a type field and a descriptor ring. It stores this decoded form beside the requested ring taken from the selector.

Each access names a segment register and gives a 32-bit offset and the current ring of the requester. The block checks presence, ring and limit. One cycle later it returns the linear address (base plus offset) or a 2-bit fault code. When a fault is reported, the address is forced to zero and is not marked valid.

Top module: `seg_xlat`

## Requirements
- R1: A selector is laid out as index in bits 15:3, table choice in bit 2 and requested ring (RPL) in bits 1:0. Only the RPL field affects translation.
- R2: The base is rebuilt from descriptor bits 31:16 (base bits 15:0), 39:32 (base bits 23:16) and 63:56 (base bits 31:24).
- R3: The 20-bit limit is taken from descriptor bits 15:0 (low) and 51:48 (high). With granularity bit 55 clear, an offset equal to the limit is accepted and an offset one above it gives fault code 2.
- R4: With granularity bit 55 set, the effective limit is the 20-bit limit followed by 12 one bits, so offsets up to {limit,12'hFFF} pass.
- R5: The linear address is base plus offset modulo 2^32.
- R6: The present bit is descriptor bit 47. After reset every segment register is not present, and an access to it gives fault code 1.
- R7: A load whose descriptor has bit 47 clear is rejected, and the segment register keeps its earlier contents.
- R8: With the descriptor ring in bits 46:45, an access passes the ring check only if max(CPL, RPL) <= DPL. Otherwise it gives fault code 3.
- R9: When several faults apply, not-present wins over privilege and privilege wins over limit.
- R10: Every access produces rsp_valid exactly one cycle later, and rsp_valid is low in cycles with no access. A faulting response carries address zero.
- R11: Fault codes are 0 none, 1 not present, 2 limit, 3 privilege. rsp_addr_valid is high exactly when the code is 0 on a valid response.
- R12: An access in the same cycle as a load to the same register uses the old contents. A load to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe for a segment register |
| ld_seg | input | SEG_W | Segment register to load (0 code, 1 data) |
| ld_selector | input | 16 | Selector being loaded |
| ld_desc | input | 64 | Descriptor matching the selector |
| req_valid | input | 1 | Access request strobe |
| req_seg | input | SEG_W | Segment register used by the access |
| req_offset | input | 32 | Offset within the segment |
| req_cpl | input | 2 | Current privilege ring of the requester |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr_valid | output | 1 | Linear address is usable |
| rsp_addr | output | 32 | Linear address, zero on fault |
| rsp_fault | output | 2 | Fault code |

## Verification
A wrong base or limit field in a cached register shows up on the first access after the load. That response arrives one cycle later and carries a wrong address, or a limit fault in the wrong place. Offsets are therefore placed exactly on and one past each effective limit. A stale or wrongly cleared present flag shows up as fault code 1 on the next access. A wrongly stored ring field shows up as fault code 3 appearing or missing. The bench crosses CPL and RPL around the DPL so that each operand of the maximum decides the outcome once.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int ADDR_W  = 32;
    localparam int LIM_W   = 20;
    localparam int GRAN_SH = 12;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_PRIV   = 2'd3
    } fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] eff_limit;
        logic [1:0]        dpl;
        logic [1:0]        rpl;
        logic              present;
        logic              big;
        logic [4:0]        kind;
    } seg_entry_t;

    typedef struct packed {
        logic              valid;
        logic              addr_valid;
        logic [ADDR_W-1:0] addr;
        fault_e            fault;
    } xlat_rsp_t;

    function automatic logic [ADDR_W-1:0] scale_limit(input logic [LIM_W-1:0] lim,
                                                      input logic gran);
        logic [ADDR_W-1:0] r;
        if (gran) r = {lim, {GRAN_SH{1'b1}}};
        else      r = {{(ADDR_W-LIM_W){1'b0}}, lim};
        return r;
    endfunction

    function automatic logic [1:0] ring_max(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_xlat_pkg::*;
(
    input  logic [15:0] selector,
    input  logic [63:0] desc,
    output seg_entry_t  entry
);
    logic [LIM_W-1:0] raw_limit;

    always_comb begin
        raw_limit       = {desc[51:48], desc[15:0]};
        entry.base      = {desc[63:56], desc[39:32], desc[31:16]};
        entry.eff_limit = scale_limit(raw_limit, desc[55]);
        entry.big       = desc[54];
        entry.present   = desc[47];
        entry.dpl       = desc[46:45];
        entry.kind      = desc[44:40];
        entry.rpl       = selector[1:0];
    end
endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEGS = 2,
    parameter int SEG_W    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_sel,
    input  seg_entry_t       wr_entry,
    input  logic [SEG_W-1:0] rd_sel,
    output seg_entry_t       rd_entry
);
    seg_entry_t regs [NUM_SEGS];

    for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && wr_entry.present && (wr_sel == SEG_W'(i))) begin
                regs[i] <= wr_entry;
            end
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int k = 0; k < NUM_SEGS; k++) begin
            if (rd_sel == SEG_W'(k)) rd_entry = regs[k];
        end
    end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_xlat_pkg::*;
(
    input  seg_entry_t        entry,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        cpl,
    output fault_e            fault,
    output logic [ADDR_W-1:0] lin_addr
);
    logic [1:0] eff_ring;
    logic       ring_ok;
    logic       in_limit;

    always_comb begin
        eff_ring = ring_max(cpl, entry.rpl);
        ring_ok  = (eff_ring <= entry.dpl);
        in_limit = (offset <= entry.eff_limit);
        if (!entry.present)  fault = FLT_ABSENT;
        else if (!ring_ok)   fault = FLT_PRIV;
        else if (!in_limit)  fault = FLT_LIMIT;
        else                 fault = FLT_NONE;
        lin_addr = (fault == FLT_NONE) ? (entry.base + offset) : '0;
    end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEGS = 2,
    parameter int SEG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic [SEG_W-1:0] ld_seg,
    input  logic [15:0]      ld_selector,
    input  logic [63:0]      ld_desc,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [31:0]      req_offset,
    input  logic [1:0]       req_cpl,
    output logic             rsp_valid,
    output logic             rsp_addr_valid,
    output logic [31:0]      rsp_addr,
    output logic [1:0]       rsp_fault
);
    seg_entry_t new_entry;
    seg_entry_t cur_entry;
    fault_e     chk_fault;
    logic [ADDR_W-1:0] chk_addr;
    xlat_rsp_t  rsp_q;

    seg_desc_unpack u_unpack (
        .selector (ld_selector),
        .desc     (ld_desc),
        .entry    (new_entry)
    );

    seg_reg_bank #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ld_valid),
        .wr_sel   (ld_seg),
        .wr_entry (new_entry),
        .rd_sel   (req_seg),
        .rd_entry (cur_entry)
    );

    seg_access_check u_check (
        .entry    (cur_entry),
        .offset   (req_offset),
        .cpl      (req_cpl),
        .fault    (chk_fault),
        .lin_addr (chk_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '{valid: 1'b0, addr_valid: 1'b0, addr: '0, fault: FLT_NONE};
        end else if (req_valid) begin
            rsp_q <= '{valid: 1'b1, addr_valid: (chk_fault == FLT_NONE),
                       addr: chk_addr, fault: chk_fault};
        end else begin
            rsp_q <= '{valid: 1'b0, addr_valid: 1'b0, addr: '0, fault: FLT_NONE};
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_addr_valid = rsp_q.addr_valid;
    assign rsp_addr       = rsp_q.addr;
    assign rsp_fault      = rsp_q.fault;
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_addr_valid,
    input logic [31:0] rsp_addr,
    input logic [1:0]  rsp_fault
);
    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_rsp_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_fault_zero_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'd0) |-> (rsp_addr == 32'd0));

    assert_addr_valid_only_clean_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_addr_valid |-> (rsp_valid && rsp_fault == 2'd0));

    assert_clean_rsp_marks_valid_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0) |-> rsp_addr_valid);

    assert_idle_no_fault_R11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_fault == 2'd0 && !rsp_addr_valid));
endmodule

bind seg_xlat seg_xlat_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .rsp_valid      (rsp_valid),
    .rsp_addr_valid (rsp_addr_valid),
    .rsp_addr       (rsp_addr),
    .rsp_fault      (rsp_fault)
);

// File: tb/seg_xlat_tb.sv
module seg_xlat_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid;
    logic [0:0]  ld_seg;
    logic [15:0] ld_selector;
    logic [63:0] ld_desc;
    logic        req_valid;
    logic [0:0]  req_seg;
    logic [31:0] req_offset;
    logic [1:0]  req_cpl;
    logic        rsp_valid;
    logic        rsp_addr_valid;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [0:0] CODE = 1'b0;
    localparam logic [0:0] DATA = 1'b1;

    always #2.5 clk = ~clk;

    seg_xlat u_dut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_selector(ld_selector), .ld_desc(ld_desc),
        .req_valid(req_valid), .req_seg(req_seg), .req_offset(req_offset), .req_cpl(req_cpl),
        .rsp_valid(rsp_valid), .rsp_addr_valid(rsp_addr_valid),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
    );

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                            input logic g, input logic p, input logic [1:0] dpl);
        logic [63:0] d = '0;
        d[15:0]  = lim[15:0];
        d[51:48] = lim[19:16];
        d[31:16] = base[15:0];
        d[39:32] = base[23:16];
        d[63:56] = base[31:24];
        d[55]    = g;
        d[54]    = 1'b1;
        d[47]    = p;
        d[46:45] = dpl;
        d[44:40] = 5'b10010;
        return d;
    endfunction

    function automatic logic [15:0] mk_sel(input logic [12:0] idx, input logic ti,
                                           input logic [1:0] rpl);
        return {idx, ti, rpl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [0:0] seg, input logic [15:0] sel, input logic [63:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = seg; ld_selector = sel; ld_desc = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic access(input string req, input logic [0:0] seg, input logic [31:0] off,
                          input logic [1:0] cpl, input logic [1:0] exp_f,
                          input logic [31:0] exp_a);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_offset = off; req_cpl = cpl;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
        check({req, " addr"}, rsp_addr, (exp_f == 2'd0) ? exp_a : 32'd0);
        check({req, " addr_valid"}, {31'd0, rsp_addr_valid}, {31'd0, exp_f == 2'd0});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R11 reset fault", {30'd0, rsp_fault}, 32'd0);
        access("R6 code absent after reset", CODE, 32'h10, 2'd0, 2'd1, 32'd0);
        access("R9 absent beats privilege", DATA, 32'h10, 2'd3, 2'd1, 32'd0);
        @(negedge clk);
        check("R10 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_byte_limit;
        load(DATA, mk_sel(13'd5, 1'b0, 2'd0), mk_desc(32'h12345678, 20'h00FFF, 1'b0, 1'b1, 2'd3));
        access("R2 R5 base plus offset", DATA, 32'h10, 2'd3, 2'd0, 32'h12345688);
        access("R3 offset at limit", DATA, 32'hFFF, 2'd3, 2'd0, 32'h12346677);
        access("R3 offset past limit", DATA, 32'h1000, 2'd3, 2'd2, 32'd0);
    endtask

    task automatic t_page_limit;
        load(DATA, mk_sel(13'd6, 1'b1, 2'd0), mk_desc(32'h00400000, 20'h00002, 1'b1, 1'b1, 2'd3));
        access("R4 scaled limit top", DATA, 32'h2FFF, 2'd3, 2'd0, 32'h00402FFF);
        access("R4 scaled limit past", DATA, 32'h3000, 2'd3, 2'd2, 32'd0);
        load(DATA, mk_sel(13'd7, 1'b0, 2'd0), mk_desc(32'hFFFFF000, 20'hFFFFF, 1'b1, 1'b1, 2'd3));
        access("R5 address wraps", DATA, 32'h2000, 2'd3, 2'd0, 32'h00001000);
        access("R4 full limit", DATA, 32'hFFFFFFFF, 2'd3, 2'd0, 32'hFFFFEFFF);
    endtask

    task automatic t_privilege;
        load(DATA, mk_sel(13'd8, 1'b0, 2'd0), mk_desc(32'h00010000, 20'h000FF, 1'b0, 1'b1, 2'd1));
        access("R8 cpl equals dpl", DATA, 32'h4, 2'd1, 2'd0, 32'h00010004);
        access("R8 cpl above dpl", DATA, 32'h4, 2'd2, 2'd3, 32'd0);
        access("R9 privilege beats limit", DATA, 32'h400, 2'd3, 2'd3, 32'd0);
        load(DATA, mk_sel(13'd8, 1'b0, 2'd2), mk_desc(32'h00010000, 20'h000FF, 1'b0, 1'b1, 2'd1));
        access("R1 R8 rpl above dpl", DATA, 32'h4, 2'd0, 2'd3, 32'd0);
        load(DATA, mk_sel(13'h1FFF, 1'b1, 2'd1), mk_desc(32'h00010000, 20'h000FF, 1'b0, 1'b1, 2'd1));
        access("R1 index and table ignored", DATA, 32'h8, 2'd0, 2'd0, 32'h00010008);
    endtask

    task automatic t_reject_and_order;
        load(CODE, mk_sel(13'd1, 1'b0, 2'd0), mk_desc(32'h00100000, 20'hFFFFF, 1'b0, 1'b1, 2'd0));
        access("R12 code loaded", CODE, 32'h20, 2'd0, 2'd0, 32'h00100020);
        load(CODE, mk_sel(13'd2, 1'b0, 2'd0), mk_desc(32'h00200000, 20'hFFFFF, 1'b0, 1'b0, 2'd0));
        access("R7 absent load rejected", CODE, 32'h20, 2'd0, 2'd0, 32'h00100020);
        access("R12 data untouched by code load", DATA, 32'h8, 2'd0, 2'd0, 32'h00010008);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = CODE; ld_selector = mk_sel(13'd3, 1'b0, 2'd0);
        ld_desc = mk_desc(32'h00300000, 20'hFFFFF, 1'b0, 1'b1, 2'd0);
        req_valid = 1'b1; req_seg = CODE; req_offset = 32'h4; req_cpl = 2'd0;
        @(negedge clk);
        ld_valid = 1'b0; req_valid = 1'b0;
        check("R12 same-cycle uses old base", rsp_addr, 32'h00100004);
        access("R12 new base after load", CODE, 32'h4, 2'd0, 2'd0, 32'h00300004);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ld_valid = 1'b0; ld_seg = '0; ld_selector = '0; ld_desc = '0;
        req_valid = 1'b0; req_seg = '0; req_offset = '0; req_cpl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_byte_limit();
        t_page_limit();
        t_privilege();
        t_reject_and_order();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule